// File: doc/BRIEF.md
# DMA Transfer Descriptor Register Front-End

This block is the software-facing side of a single-channel DMA engine. Through a plain 32-bit register bus, software writes a descriptor: addresses, lengths, strides and a repeat flag. It then writes the start register to queue that descriptor. Every queued descriptor is tagged with a 5-bit identifier allocated by hardware. Queued descriptors are handed in order to a downstream data mover over a valid/ready request port. The mover reports finished transfers by identifier on a completion port. The block keeps a per-identifier done bitmask and two interrupt sources, one for a descriptor taken and one for a transfer finished. Moving data and mastering a bus belong to the mover, not to this block.

The dispatcher is a four-state machine. In IDLE nothing is in flight; the go transition to OFFER fires when the channel is enabled, not paused and the queue is not empty. OFFER presents the queue head; the take transition (ready seen) pops the queue, latches the descriptor as in flight and moves to WAIT. WAIT holds until a completion whose identifier matches the in-flight one. Its finish transition returns to IDLE for a one-shot descriptor. Its repeat transition goes to RECYCLE for a repeating one. RECYCLE presents the same in-flight descriptor again, and its re-take transition (ready seen) returns to WAIT. From every state, the abort transition (a control write with the enable bit clear) returns to IDLE and empties the queue.

Register offsets: 0x080 interrupt mask, 0x084 interrupt pending, 0x088 interrupt source, 0x400 control, 0x404 next identifier, 0x408 start, 0x40C flags, 0x410 destination address, 0x414 source address, 0x418 X length, 0x41C Y length, 0x420 destination stride, 0x424 source stride, 0x428 done mask, 0x42C active identifier, 0x430 status. Reads are combinational on the address; writes take effect at the clock edge.

Top module: `xfer_desc_frontend`

## Requirements
- R1: After reset, the mask register reads 3, pending, source, done mask, next identifier, start and status read 0, and irq and mv_valid are low.
- R2: The address, length and stride registers read back the full 32-bit value written. Flags keep only bit 0, the mask keeps bits 1:0, and control keeps bit 0 (enable) and bit 1 (pause).
- R3: A start write with bit 0 set, made while enabled and with fewer than DEPTH entries queued, queues the descriptor under the current next identifier and increments that identifier modulo 32. The start register reads 1 while DEPTH entries are queued and 0 otherwise. A start write while full or disabled changes nothing.
- R4: When enabled and not paused, queued descriptors are offered on the mover port one at a time, in submission order, with their identifier and programmed fields. mv_valid holds until mv_ready. The taken identifier then reads from the active identifier register, and status bit 0 is 1 while a descriptor is in flight.
- R5: While pause (control bit 1) is set, no queued descriptor is offered.
- R6: A taken descriptor sets pending bit 0 (start-of-transfer).
- R7: A completion whose identifier equals the in-flight one sets done mask bit n for that identifier n and pending bit 1 (end-of-transfer). A completion with any other identifier is ignored.
- R8: Allocating identifier n to a new submission clears done mask bit n.
- R9: Writing ones to the pending register clears those bits. A set event in the same cycle wins over the clear.
- R10: irq is high exactly when some pending bit has its mask bit at 0. The source register reads pending AND NOT mask.
- R11: A descriptor with flags bit 0 set is offered again, with the same identifier and fields, each time it completes. No start write is needed and no identifier is allocated.
- R12: Writing control with bit 0 clear empties the queue, drops any in-flight descriptor and returns to IDLE. mv_valid is low afterwards, and status reads 0 (bit 0 busy, bits 15:8 queue level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| mv_valid | output | 1 | Descriptor offered to mover |
| mv_ready | input | 1 | Mover takes the offered descriptor |
| mv_id | output | 5 | Identifier of the offered descriptor |
| mv_cyclic | output | 1 | Offered descriptor repeats |
| mv_dst_addr | output | 32 | Destination address |
| mv_src_addr | output | 32 | Source address |
| mv_xlen | output | 32 | X length as programmed |
| mv_ylen | output | 32 | Y length as programmed |
| mv_dst_stride | output | 32 | Destination stride |
| mv_src_stride | output | 32 | Source stride |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_id | input | 5 | Identifier of the completed transfer |

## Verification
The bench builds the block with its default queue depth of 4 and a 12-bit address. A depth of 4 lets a paused channel fill the queue with only four start writes, which makes the full read-back and the ignored fifth start reachable. It also keeps identifier wrap within reach: 25 further submissions, with a flush after every fourth, bring the counter back to 0. That exposes the done bit being cleared when identifier 0 is reused.

// File: rtl/xdf_pkg.sv
`timescale 1ns/1ps
package xdf_pkg;

    localparam int ID_W   = 5;
    localparam int WORD_W = 32;
    localparam int NUM_IDS = 1 << ID_W;
    localparam int NUM_IRQ = 2;

    localparam logic [11:0] OFS_IRQ_MASK  = 12'h080;
    localparam logic [11:0] OFS_IRQ_PEND  = 12'h084;
    localparam logic [11:0] OFS_IRQ_SRC   = 12'h088;
    localparam logic [11:0] OFS_CTRL      = 12'h400;
    localparam logic [11:0] OFS_NEXT_ID   = 12'h404;
    localparam logic [11:0] OFS_START     = 12'h408;
    localparam logic [11:0] OFS_FLAGS     = 12'h40C;
    localparam logic [11:0] OFS_DST_ADDR  = 12'h410;
    localparam logic [11:0] OFS_SRC_ADDR  = 12'h414;
    localparam logic [11:0] OFS_XLEN      = 12'h418;
    localparam logic [11:0] OFS_YLEN      = 12'h41C;
    localparam logic [11:0] OFS_DST_STRD  = 12'h420;
    localparam logic [11:0] OFS_SRC_STRD  = 12'h424;
    localparam logic [11:0] OFS_DONE      = 12'h428;
    localparam logic [11:0] OFS_ACTIVE_ID = 12'h42C;
    localparam logic [11:0] OFS_STATUS    = 12'h430;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              cyclic;
        logic [WORD_W-1:0] dst_addr;
        logic [WORD_W-1:0] src_addr;
        logic [WORD_W-1:0] xlen;
        logic [WORD_W-1:0] ylen;
        logic [WORD_W-1:0] dst_stride;
        logic [WORD_W-1:0] src_stride;
    } xdesc_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OFFER   = 2'd1,
        ST_WAIT    = 2'd2,
        ST_RECYCLE = 2'd3
    } disp_state_e;

endpackage

// File: rtl/xdf_queue.sv
`timescale 1ns/1ps
module xdf_queue
    import xdf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  xdesc_t                        din,
    input  logic                          pop,
    input  logic                          flush,
    output xdesc_t                        head,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    xdesc_t           slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // storage needs no reset: a slot is only read after it is written
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            slots[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == LVL_W'(DEPTH));
    assign empty = (count == '0);
    assign level = count;

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full)) else $error("push into full queue"); // R3
    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty)) else $error("pop from empty queue"); // R4
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH)) else $error("queue level out of range"); // R3

endmodule

// File: rtl/xdf_irq.sv
`timescale 1ns/1ps
module xdf_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            pend_wr,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] src,
    output logic            irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (mask_wr) begin
            mask <= wdata;
        end
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[gi] <= 1'b0;
            end else if (evt[gi]) begin
                pend[gi] <= 1'b1;
            end else if (pend_wr && wdata[gi]) begin
                pend[gi] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[gi] |=> pend[gi]) else $error("event lost"); // R9
        AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_wr && wdata[gi] && !evt[gi]) |=> !pend[gi]) else $error("clear lost"); // R9
    end

    assign src = pend & ~mask;
    assign irq = |src;

    AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq) else $error("irq while fully masked"); // R10

endmodule

// File: rtl/xdf_dispatch.sv
`timescale 1ns/1ps
module xdf_dispatch
    import xdf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            pause,
    input  logic            flush,
    input  logic            q_empty,
    input  xdesc_t          q_head,
    output logic            q_pop,
    output logic            mv_valid,
    input  logic            mv_ready,
    output xdesc_t          mv_desc,
    input  logic            cpl_valid,
    input  logic [ID_W-1:0] cpl_id,
    output logic            sot_evt,
    output logic            eot_evt,
    output logic [ID_W-1:0] active_id,
    output logic            busy
);
    disp_state_e state_q;
    disp_state_e state_d;
    xdesc_t      held_q;
    logic        cpl_hit;

    assign cpl_hit = cpl_valid && (cpl_id == held_q.id);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!flush && en && !pause && !q_empty) begin
                    state_d = ST_OFFER;                        // go
                end
            end
            ST_OFFER: begin
                if (flush) begin
                    state_d = ST_IDLE;                         // abort
                end else if (mv_ready) begin
                    state_d = ST_WAIT;                         // take
                end
            end
            ST_WAIT: begin
                if (flush) begin
                    state_d = ST_IDLE;                         // abort
                end else if (cpl_hit) begin
                    state_d = held_q.cyclic ? ST_RECYCLE : ST_IDLE; // repeat / finish
                end
            end
            ST_RECYCLE: begin
                if (flush) begin
                    state_d = ST_IDLE;                         // abort
                end else if (mv_ready) begin
                    state_d = ST_WAIT;                         // re-take
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        q_pop    = 1'b0;
        mv_valid = 1'b0;
        mv_desc  = held_q;
        sot_evt  = 1'b0;
        eot_evt  = 1'b0;
        unique case (state_q)
            ST_OFFER: begin
                mv_valid = 1'b1;
                mv_desc  = q_head;
                if (mv_ready && !flush) begin
                    q_pop   = 1'b1;
                    sot_evt = 1'b1;
                end
            end
            ST_WAIT: begin
                if (cpl_hit && !flush) begin
                    eot_evt = 1'b1;
                end
            end
            ST_RECYCLE: begin
                mv_valid = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (q_pop) begin
            held_q <= q_head;
        end
    end

    assign active_id = held_q.id;
    assign busy      = (state_q != ST_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_ready && !flush) |=> mv_valid) else $error("request dropped"); // R4
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pause) |=> (state_q == ST_IDLE)) else $error("offer while paused"); // R5
    AST_RECYCLE_SAME_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_evt && held_q.cyclic) |=> (mv_valid && mv_desc.id == $past(held_q.id)))
        else $error("repeat lost its identifier"); // R11
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !mv_valid) else $error("request after abort"); // R12

endmodule

// File: rtl/xfer_desc_frontend.sv
`timescale 1ns/1ps
module xfer_desc_frontend
    import xdf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              mv_valid,
    input  logic              mv_ready,
    output logic [4:0]        mv_id,
    output logic              mv_cyclic,
    output logic [31:0]       mv_dst_addr,
    output logic [31:0]       mv_src_addr,
    output logic [31:0]       mv_xlen,
    output logic [31:0]       mv_ylen,
    output logic [31:0]       mv_dst_stride,
    output logic [31:0]       mv_src_stride,
    input  logic              cpl_valid,
    input  logic [4:0]        cpl_id
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    // ---------------- register file ----------------
    logic              ctl_en, ctl_pause, cfg_cyclic;
    logic [WORD_W-1:0] cfg_dst, cfg_src, cfg_xlen, cfg_ylen, cfg_dstr, cfg_sstr;
    logic [ID_W-1:0]   next_id;
    logic [NUM_IDS-1:0] done_mask;

    logic              wr_ctrl, wr_start, start_acc, flush;
    logic              q_full, q_empty, q_pop;
    logic [LVL_W-1:0]  q_level;
    xdesc_t            q_head, new_desc, mv_desc;
    logic              sot_evt, eot_evt, busy;
    logic [ID_W-1:0]   active_id;
    logic [NUM_IRQ-1:0] irq_pend, irq_mask, irq_src;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wr_ctrl   = bus_we && hit(bus_addr, OFS_CTRL);
    assign wr_start  = bus_we && hit(bus_addr, OFS_START) && bus_wdata[0];
    assign start_acc = wr_start && ctl_en && !q_full;
    assign flush     = wr_ctrl && !bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en     <= 1'b0;
            ctl_pause  <= 1'b0;
            cfg_cyclic <= 1'b0;
            cfg_dst    <= '0;
            cfg_src    <= '0;
            cfg_xlen   <= '0;
            cfg_ylen   <= '0;
            cfg_dstr   <= '0;
            cfg_sstr   <= '0;
        end else if (bus_we) begin
            if (hit(bus_addr, OFS_CTRL)) begin
                ctl_en    <= bus_wdata[0];
                ctl_pause <= bus_wdata[1];
            end
            if (hit(bus_addr, OFS_FLAGS))    cfg_cyclic <= bus_wdata[0];
            if (hit(bus_addr, OFS_DST_ADDR)) cfg_dst    <= bus_wdata;
            if (hit(bus_addr, OFS_SRC_ADDR)) cfg_src    <= bus_wdata;
            if (hit(bus_addr, OFS_XLEN))     cfg_xlen   <= bus_wdata;
            if (hit(bus_addr, OFS_YLEN))     cfg_ylen   <= bus_wdata;
            if (hit(bus_addr, OFS_DST_STRD)) cfg_dstr   <= bus_wdata;
            if (hit(bus_addr, OFS_SRC_STRD)) cfg_sstr   <= bus_wdata;
        end
    end

    // ---------------- identifier allocation ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_id <= '0;
        end else if (start_acc) begin
            next_id <= next_id + 1'b1;
        end
    end

    always_comb begin
        new_desc            = '0;
        new_desc.id         = next_id;
        new_desc.cyclic     = cfg_cyclic;
        new_desc.dst_addr   = cfg_dst;
        new_desc.src_addr   = cfg_src;
        new_desc.xlen       = cfg_xlen;
        new_desc.ylen       = cfg_ylen;
        new_desc.dst_stride = cfg_dstr;
        new_desc.src_stride = cfg_sstr;
    end

    // ---------------- done mask, one bit per identifier ----------------
    for (genvar gi = 0; gi < NUM_IDS; gi++) begin : g_done
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                done_mask[gi] <= 1'b0;
            end else if (start_acc && next_id == ID_W'(gi)) begin
                done_mask[gi] <= 1'b0;
            end else if (eot_evt && active_id == ID_W'(gi)) begin
                done_mask[gi] <= 1'b1;
            end
        end
    end

    // ---------------- sub-blocks ----------------
    xdf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (start_acc),
        .din   (new_desc),
        .pop   (q_pop),
        .flush (flush),
        .head  (q_head),
        .full  (q_full),
        .empty (q_empty),
        .level (q_level)
    );

    xdf_dispatch u_dispatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .pause     (ctl_pause),
        .flush     (flush),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .q_pop     (q_pop),
        .mv_valid  (mv_valid),
        .mv_ready  (mv_ready),
        .mv_desc   (mv_desc),
        .cpl_valid (cpl_valid),
        .cpl_id    (cpl_id),
        .sot_evt   (sot_evt),
        .eot_evt   (eot_evt),
        .active_id (active_id),
        .busy      (busy)
    );

    xdf_irq #(.NSRC(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     ({eot_evt, sot_evt}),
        .pend_wr (bus_we && hit(bus_addr, OFS_IRQ_PEND)),
        .mask_wr (bus_we && hit(bus_addr, OFS_IRQ_MASK)),
        .wdata   (bus_wdata[NUM_IRQ-1:0]),
        .pend    (irq_pend),
        .mask    (irq_mask),
        .src     (irq_src),
        .irq     (irq)
    );

    assign mv_id         = mv_desc.id;
    assign mv_cyclic     = mv_desc.cyclic;
    assign mv_dst_addr   = mv_desc.dst_addr;
    assign mv_src_addr   = mv_desc.src_addr;
    assign mv_xlen       = mv_desc.xlen;
    assign mv_ylen       = mv_desc.ylen;
    assign mv_dst_stride = mv_desc.dst_stride;
    assign mv_src_stride = mv_desc.src_stride;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_IRQ_MASK):  bus_rdata = 32'(irq_mask);
            ADDR_W'(OFS_IRQ_PEND):  bus_rdata = 32'(irq_pend);
            ADDR_W'(OFS_IRQ_SRC):   bus_rdata = 32'(irq_src);
            ADDR_W'(OFS_CTRL):      bus_rdata = {30'd0, ctl_pause, ctl_en};
            ADDR_W'(OFS_NEXT_ID):   bus_rdata = 32'(next_id);
            ADDR_W'(OFS_START):     bus_rdata = 32'(q_full);
            ADDR_W'(OFS_FLAGS):     bus_rdata = 32'(cfg_cyclic);
            ADDR_W'(OFS_DST_ADDR):  bus_rdata = cfg_dst;
            ADDR_W'(OFS_SRC_ADDR):  bus_rdata = cfg_src;
            ADDR_W'(OFS_XLEN):      bus_rdata = cfg_xlen;
            ADDR_W'(OFS_YLEN):      bus_rdata = cfg_ylen;
            ADDR_W'(OFS_DST_STRD):  bus_rdata = cfg_dstr;
            ADDR_W'(OFS_SRC_STRD):  bus_rdata = cfg_sstr;
            ADDR_W'(OFS_DONE):      bus_rdata = 32'(done_mask);
            ADDR_W'(OFS_ACTIVE_ID): bus_rdata = 32'(active_id);
            ADDR_W'(OFS_STATUS):    bus_rdata = (32'(q_level) << 8) | 32'(busy);
            default:                bus_rdata = '0;
        endcase
    end

    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (next_id == $past(next_id) + 1'b1)) else $error("identifier not advanced"); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && (q_full || !ctl_en)) |=> $stable(next_id)) else $error("ignored start allocated"); // R3
    AST_DONE_ON_EOT: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_evt && !start_acc) |=> done_mask[$past(active_id)]) else $error("done bit not set"); // R7

endmodule

// File: tb/xfer_desc_frontend_bench.sv
`timescale 1ns/1ps
module xfer_desc_frontend_bench;

    localparam logic [11:0] A_MASK = 12'h080, A_PEND = 12'h084, A_SRCQ = 12'h088;
    localparam logic [11:0] A_CTRL = 12'h400, A_ID = 12'h404, A_START = 12'h408;
    localparam logic [11:0] A_FLAGS = 12'h40C, A_DST = 12'h410, A_SRC = 12'h414;
    localparam logic [11:0] A_XLEN = 12'h418, A_YLEN = 12'h41C, A_DSTR = 12'h420;
    localparam logic [11:0] A_SSTR = 12'h424, A_DONE = 12'h428, A_ACT = 12'h42C;
    localparam logic [11:0] A_STAT = 12'h430;

    localparam int NV = 24;
    localparam bit V_WR [NV] = '{1,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0};
    localparam logic [11:0] V_ADDR [NV] = '{
        A_DST, A_DST, A_SRC, A_SRC, A_XLEN, A_XLEN, A_YLEN, A_YLEN,
        A_DSTR, A_DSTR, A_SSTR, A_SSTR, A_FLAGS, A_FLAGS, A_MASK, A_MASK,
        A_MASK, A_MASK, A_FLAGS, A_FLAGS, A_CTRL, A_CTRL, A_CTRL, A_CTRL};
    localparam logic [31:0] V_DATA [NV] = '{
        32'hA5A50010, 32'hA5A50010, 32'h5A5A0020, 32'h5A5A0020,
        32'h000000FF, 32'h000000FF, 32'h00000003, 32'h00000003,
        32'h00000400, 32'h00000400, 32'h00000800, 32'h00000800,
        32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFC, 32'h00000000,
        32'h00000007, 32'h00000003, 32'h00000000, 32'h00000000,
        32'h00000002, 32'h00000002, 32'h00000000, 32'h00000000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, mv_valid, mv_cyclic;
    logic        mv_ready = 1'b0;
    logic [4:0]  mv_id;
    logic [31:0] mv_dst_addr, mv_src_addr, mv_xlen, mv_ylen, mv_dst_stride, mv_src_stride;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_id = '0;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;
    int exp_id = 0;

    always #2 clk = ~clk;

    xfer_desc_frontend u_xfer_desc_frontend (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_id(mv_id), .mv_cyclic(mv_cyclic),
        .mv_dst_addr(mv_dst_addr), .mv_src_addr(mv_src_addr), .mv_xlen(mv_xlen),
        .mv_ylen(mv_ylen), .mv_dst_stride(mv_dst_stride), .mv_src_stride(mv_src_stride),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic take();
        @(negedge clk); mv_ready = 1'b1;
        @(negedge clk); mv_ready = 1'b0;
    endtask

    task automatic complete(input logic [4:0] id);
        @(negedge clk); cpl_valid = 1'b1; cpl_id = id;
        @(negedge clk); cpl_valid = 1'b0;
    endtask

    task automatic submit();
        wr(A_START, 32'h1);
        exp_id = (exp_id + 1) % 32;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mv_valid", 32'(mv_valid), 0);
        rdchk("R1 mask", A_MASK, 3);
        rdchk("R1 pending", A_PEND, 0);
        rdchk("R1 done", A_DONE, 0);
        rdchk("R1 next id", A_ID, 0);
        rdchk("R1 start", A_START, 0);
        rdchk("R1 status", A_STAT, 0);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) wr(V_ADDR[i], V_DATA[i]);
            else rdchk($sformatf("R2 vec%0d", i), V_ADDR[i], V_DATA[i]);
        end

        // R4 R6 R7 single dispatch
        wr(A_CTRL, 32'h1);
        wr(A_DST, 32'h1000);
        wr(A_XLEN, 32'h3F);
        submit();
        rdchk("R3 next id", A_ID, 1);
        @(negedge clk);
        chk("R4 valid", 32'(mv_valid), 1);
        chk("R4 id", 32'(mv_id), 0);
        chk("R4 dst", mv_dst_addr, 32'h1000);
        chk("R4 src", mv_src_addr, 32'h5A5A0020);
        chk("R4 xlen", mv_xlen, 32'h3F);
        chk("R4 dstride", mv_dst_stride, 32'h400);
        take();
        chk("R4 valid after take", 32'(mv_valid), 0);
        rdchk("R4 active", A_ACT, 0);
        rdchk("R4 status busy", A_STAT, 1);
        rdchk("R6 sot pending", A_PEND, 1);
        chk("R10 masked irq", 32'(irq), 0);
        complete(5'd7);
        rdchk("R7 wrong id done", A_DONE, 0);
        rdchk("R7 wrong id pend", A_PEND, 1);
        complete(5'd0);
        rdchk("R7 done", A_DONE, 1);
        rdchk("R7 eot pend", A_PEND, 3);
        rdchk("R7 idle", A_STAT, 0);

        // R10 masking
        wr(A_MASK, 32'h2);
        chk("R10 irq", 32'(irq), 1);
        rdchk("R10 source", A_SRCQ, 1);
        wr(A_MASK, 32'h3);
        chk("R10 irq masked", 32'(irq), 0);
        rdchk("R10 source masked", A_SRCQ, 0);
        wr(A_MASK, 32'h0);
        rdchk("R10 source all", A_SRCQ, 3);

        // R9 write-one-to-clear
        wr(A_PEND, 32'h2);
        rdchk("R9 clear eot", A_PEND, 1);
        wr(A_PEND, 32'h1);
        rdchk("R9 clear sot", A_PEND, 0);
        chk("R9 irq low", 32'(irq), 0);

        // R9 set wins over clear
        submit();
        @(negedge clk);
        chk("R9 offered", 32'(mv_valid), 1);
        mv_ready = 1'b1; bus_we = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h1;
        @(negedge clk);
        mv_ready = 1'b0; bus_we = 1'b0;
        rdchk("R9 set wins", A_PEND, 1);
        complete(5'd1);
        rdchk("R7 done 1", A_DONE, 3);
        wr(A_PEND, 32'h3);

        // R11 cyclic
        wr(A_FLAGS, 32'h1);
        wr(A_DST, 32'h2000);
        submit();
        @(negedge clk);
        chk("R11 first offer", 32'(mv_id), 2);
        take();
        complete(5'd2);
        chk("R11 reoffer valid", 32'(mv_valid), 1);
        chk("R11 reoffer id", 32'(mv_id), 2);
        chk("R11 reoffer dst", mv_dst_addr, 32'h2000);
        chk("R11 cyclic flag", 32'(mv_cyclic), 1);
        rdchk("R11 no new id", A_ID, 3);
        rdchk("R11 done", A_DONE, 7);
        take();
        rdchk("R11 active", A_ACT, 2);

        // R12 abort
        wr(A_CTRL, 32'h0);
        chk("R12 valid low", 32'(mv_valid), 0);
        rdchk("R12 status", A_STAT, 0);
        wr(A_FLAGS, 32'h0);

        // R3 R5 fill while paused
        wr(A_CTRL, 32'h3);
        for (int k = 0; k < 4; k++) begin
            wr(A_DST, 32'h3000 + 32'(exp_id));
            submit();
        end
        rdchk("R3 full", A_START, 1);
        rdchk("R3 level", A_STAT, 32'h400);
        chk("R5 paused", 32'(mv_valid), 0);
        wr(A_START, 32'h1);
        rdchk("R3 full ignored", A_ID, 7);

        // R4 order after unpause
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        chk("R4 order first id", 32'(mv_id), 3);
        chk("R4 order first dst", mv_dst_addr, 32'h3003);
        take();
        rdchk("R3 not full", A_START, 0);
        complete(5'd3);
        @(negedge clk);
        chk("R4 order second valid", 32'(mv_valid), 1);
        chk("R4 order second id", 32'(mv_id), 4);
        chk("R4 order second dst", mv_dst_addr, 32'h3004);

        // R12 flush queue
        wr(A_CTRL, 32'h0);
        chk("R12 flush valid", 32'(mv_valid), 0);
        rdchk("R12 flush status", A_STAT, 0);
        rdchk("R12 flush start", A_START, 0);
        wr(A_START, 32'h1);
        rdchk("R3 disabled ignored", A_ID, 7);

        // R3 wrap and R8 reallocation
        wr(A_CTRL, 32'h3);
        for (int i = 0; i < 25; i++) begin
            submit();
            if (i % 4 == 3) begin
                wr(A_CTRL, 32'h0);
                wr(A_CTRL, 32'h3);
            end
        end
        rdchk("R3 wrap", A_ID, 32'(exp_id));
        rdchk("R8 done before", A_DONE, 32'hF);
        submit();
        rdchk("R8 realloc clears", A_DONE, 32'hE);
        rdchk("R3 after wrap", A_ID, 1);
        wr(A_CTRL, 32'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule